// File: doc/BRIEF.md
# Serial Memory Command Engine

This block sits behind a serial byte front-end and acts on the commands sent to a small byte-addressed memory of 256 locations. The front-end hands over each received byte on a valid/ready input stream. It takes each response byte to shift out from a valid/ready output stream. A plain select input frames each transaction: raising it starts a new command, and dropping it ends whatever is in progress.

Two commands are decoded. A sequential read takes one address byte and then streams memory contents without limit. Its internal address counter steps by one per byte and wraps from the top location to zero. A status read streams a status byte built from two protect inputs, a write-enable input and a busy input. A set of preload ports fills the storage array so that read data is known.

Back-pressure rules: input bytes are accepted in every cycle in which select is high (`rx_ready_o` follows `sel_i`), and never while select is low. An output byte, once offered, keeps `tx_valid_o` high and `tx_data_o` unchanged until `tx_ready_i` takes it. The next byte is offered in the cycle after each transfer.

Top module: `sercmd_engine`

## Requirements
- R1: After reset, with select low, `tx_valid_o` and `rx_ready_o` are both 0.
- R2: The first byte after select rises is the opcode. Opcode 0x03 followed by one address byte makes the first output byte the memory content at that address.
- R3: During a read, each accepted output byte is followed by the content of the next higher address.
- R4: After location 0xFF the read continues at location 0x00, so the whole array can be read in one transaction.
- R5: Input bytes accepted after the address byte of a read do not change the read data sequence.
- R6: Opcode 0x05 with busy low offers a status byte with bits 7..4 = 0, bits 3..2 = the protect inputs (bit 3 from `protect_i[1]`), bit 1 = the write-enable input and bit 0 = 0.
- R7: With busy high when the status byte is prepared, the status byte is 0x01.
- R8: The status byte is offered again for every further byte taken while select stays low-to-high active (select high).
- R9: Any opcode other than 0x03 or 0x05 yields no output byte, and every later input byte is ignored until select drops, including a later 0x03.
- R10: One cycle after select is sampled low, `tx_valid_o` is 0. The next select starts again at opcode decode.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds its value.
- R12: `rx_ready_o` is 1 while select is high and 0 while it is low.
- R13: A preload write stores `pre_data_i` at `pre_addr_i`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Transaction select, active high |
| rx_valid_i | input | 1 | Received byte present |
| rx_ready_o | output | 1 | Received byte accepted |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Response byte offered |
| tx_ready_i | input | 1 | Response byte taken |
| tx_data_o | output | 8 | Response byte |
| busy_i | input | 1 | Programming cycle in progress |
| protect_i | input | 2 | Block-protect bits |
| wr_en_latch_i | input | 1 | Write-enable latch state |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | 8 | Preload address |
| pre_data_i | input | 8 | Preload data |

## Verification
Reads are tried from a mid-array start, from just below the top location, and across the full array plus a few bytes. This separates a correct counter from one that saturates, misses the wrap or skips. The bench feeds junk bytes, including valid opcodes, in the middle of a read, and it stalls the output for several cycles, which separates dropped and repeated bytes from correct hand-off. Status reads with different protect and write-enable settings, with busy low and then high, show whether the bit positions and the busy masking are right. An unknown opcode followed by a read opcode, and an aborted read followed by a fresh one, check that decode only restarts on a new select.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  typedef enum logic [2:0] {
    ST_OPC  = 3'd0,
    ST_ADR  = 3'd1,
    ST_RD   = 3'd2,
    ST_STS  = 3'd3,
    ST_DROP = 3'd4
  } mode_e;

  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_STAT = 8'h05;
endpackage

// File: rtl/sercmd_store.sv
module sercmd_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/sercmd_status.sv
module sercmd_status #(
  parameter int DATA_W = 8
) (
  input  logic              busy_i,
  input  logic [1:0]        protect_i,
  input  logic              wel_i,
  output logic [DATA_W-1:0] sts_o
);
  always_comb begin
    sts_o = '0;
    if (busy_i) begin
      // only the ready/busy flag carries meaning during programming
      sts_o[0] = 1'b1;
    end else begin
      sts_o[3:2] = protect_i;
      sts_o[1]   = wel_i;
    end
  end
endmodule

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
  import sercmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sel_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic [DATA_W-1:0] sts_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output mode_e             mode_o,
  output logic [ADDR_W-1:0] addr_o
);
  mode_e             mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              txv_q;
  logic [DATA_W-1:0] txd_q;
  logic              rx_fire;
  logic              tx_fire;
  logic [ADDR_W-1:0] rx_addr;

  assign rx_ready_o = sel_i;
  assign rx_fire    = sel_i && rx_valid_i;
  assign tx_fire    = txv_q && tx_ready_i;
  assign rx_addr    = rx_data_i[ADDR_W-1:0];
  assign rd_addr_o  = (mode_q == ST_ADR) ? rx_addr : addr_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= ST_OPC;
      addr_q <= '0;
      txv_q  <= 1'b0;
      txd_q  <= '0;
    end else if (!sel_i) begin
      mode_q <= ST_OPC;
      txv_q  <= 1'b0;
    end else begin
      unique case (mode_q)
        ST_OPC: if (rx_fire) begin
          if (rx_data_i == OPC_READ) begin
            mode_q <= ST_ADR;
          end else if (rx_data_i == OPC_STAT) begin
            mode_q <= ST_STS;
            txd_q  <= sts_i;
            txv_q  <= 1'b1;
          end else begin
            mode_q <= ST_DROP;
          end
        end
        ST_ADR: if (rx_fire) begin
          mode_q <= ST_RD;
          txd_q  <= rd_data_i;
          txv_q  <= 1'b1;
          addr_q <= rx_addr + 1'b1;
        end
        ST_RD: if (tx_fire) begin
          txd_q  <= rd_data_i;
          addr_q <= addr_q + 1'b1;
        end
        ST_STS: if (tx_fire) begin
          txd_q <= sts_i;
        end
        default: ;
      endcase
    end
  end

  assign tx_valid_o = txv_q;
  assign tx_data_o  = txd_q;
  assign mode_o     = mode_q;
  assign addr_o     = addr_q;
endmodule

// File: rtl/sercmd_engine.sv
module sercmd_engine
  import sercmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sel_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              busy_i,
  input  logic [1:0]        protect_i,
  input  logic              wr_en_latch_i,
  input  logic              pre_we_i,
  input  logic [ADDR_W-1:0] pre_addr_i,
  input  logic [DATA_W-1:0] pre_data_i
);
  logic [DATA_W-1:0] sts_w;
  logic [ADDR_W-1:0] rd_addr_w;
  logic [DATA_W-1:0] rd_data_w;
  mode_e             mode_w;
  logic [ADDR_W-1:0] addr_w;

  sercmd_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (pre_we_i),
    .waddr_i (pre_addr_i),
    .wdata_i (pre_data_i),
    .raddr_i (rd_addr_w),
    .rdata_o (rd_data_w)
  );

  sercmd_status #(.DATA_W(DATA_W)) u_status (
    .busy_i    (busy_i),
    .protect_i (protect_i),
    .wel_i     (wr_en_latch_i),
    .sts_o     (sts_w)
  );

  sercmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sel_i      (sel_i),
    .rx_valid_i (rx_valid_i),
    .rx_ready_o (rx_ready_o),
    .rx_data_i  (rx_data_i),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .sts_i      (sts_w),
    .rd_addr_o  (rd_addr_w),
    .rd_data_i  (rd_data_w),
    .mode_o     (mode_w),
    .addr_o     (addr_w)
  );
endmodule

// File: rtl/sercmd_engine_chk.sv
module sercmd_engine_chk
  import sercmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              sel_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              busy_i,
  input mode_e             mode,
  input logic [ADDR_W-1:0] addr_q
);
  localparam logic [DATA_W-1:0] BUSY_ONLY = {{(DATA_W-1){1'b0}}, 1'b1};

  p_deselect_clears_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !sel_i |=> !tx_valid_o);

  p_hold_on_stall_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i && tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i && mode == ST_RD && tx_valid_o && tx_ready_i)
      |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  p_busy_mask_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i && mode == ST_STS && tx_valid_o && tx_ready_i && busy_i)
      |=> (tx_data_o == BUSY_ONLY));

  p_status_upper_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == ST_STS && tx_valid_o) |-> (tx_data_o[DATA_W-1:4] == '0));

  p_bad_opcode_silent_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode == ST_DROP) |-> !tx_valid_o);
endmodule

bind sercmd_engine sercmd_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .sel_i      (sel_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .busy_i     (busy_i),
  .mode       (mode_w),
  .addr_q     (addr_w)
);

// File: tb/sercmd_engine_tb_top.sv
`timescale 1ns/1ps
module sercmd_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       sel, rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0] rx_data, tx_data;
  logic       busy, wel, pre_we;
  logic [1:0] prot;
  logic [7:0] pre_addr, pre_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  sercmd_engine dut_i (
    .clk_i(clk), .rst_i(rst), .sel_i(sel),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .busy_i(busy), .protect_i(prot), .wr_en_latch_i(wel),
    .pre_we_i(pre_we), .pre_addr_i(pre_addr), .pre_data_i(pre_data)
  );

  task automatic chk(input bit ok, input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
    end
  endtask

  // monitor: scoreboard pops on each output transfer
  always @(negedge clk) begin
    #1;
    if (!rst && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected byte", tx_data, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(tx_data == e, t, tx_data, e);
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic take(input logic [7:0] e, input string rq, input int stall);
    exp_q.push_back(e);
    tag_q.push_back(rq);
    for (int s = 0; s < stall; s++) @(negedge clk);
    if (stall > 0) chk(tx_valid && tx_data == e, "R11 held during stall", tx_data, e);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic select();
    @(negedge clk); sel = 1'b1;
    #1 chk(rx_ready == 1'b1, "R12 ready when selected", {7'b0, rx_ready}, 8'h01);
  endtask

  task automatic deselect();
    @(negedge clk); sel = 1'b0;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R10 valid cleared", {7'b0, tx_valid}, 8'h00);
    chk(rx_ready == 1'b0, "R12 not ready when idle", {7'b0, rx_ready}, 8'h00);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; sel = 1'b0; rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b0;
    busy = 1'b0; wel = 1'b0; prot = 2'b00; pre_we = 1'b0; pre_addr = 8'h00; pre_data = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R1 reset valid", {7'b0, tx_valid}, 8'h00);
    chk(rx_ready == 1'b0, "R1 reset ready", {7'b0, rx_ready}, 8'h00);

    // R13: preload the array with a computed pattern
    for (int a = 0; a < 256; a++) begin
      model[a] = 8'((a * 29 + 7) ^ (a >> 3));
      @(negedge clk); pre_we = 1'b1; pre_addr = 8'(a); pre_data = model[a];
    end
    @(negedge clk); pre_we = 1'b0;

    // R2, R3, R13: mid-array read
    select(); send(8'h03); send(8'h40);
    take(model[8'h40], "R2 first byte", 0);
    for (int k = 1; k < 6; k++) take(model[8'h40 + k], "R3 next byte", 0);
    deselect();

    // R4: wrap near the top
    select(); send(8'h03); send(8'hFE);
    for (int k = 0; k < 4; k++) take(model[8'(8'hFE + k)], "R4 wrap", 0);
    deselect();

    // R5, R11: junk input and stalls during a read
    select(); send(8'h03); send(8'h80);
    take(model[8'h80], "R2 first byte", 3);
    send(8'h05); send(8'hAA);
    take(model[8'h81], "R5 junk ignored", 0);
    send(8'h03);
    take(model[8'h82], "R5 junk ignored", 4);
    take(model[8'h83], "R3 next byte", 0);
    deselect();

    // R6, R8: status reads
    prot = 2'b10; wel = 1'b1;
    select(); send(8'h05);
    for (int k = 0; k < 3; k++) take(8'h0A, "R8 status repeat", 0);
    deselect();
    prot = 2'b01; wel = 1'b0;
    select(); send(8'h05);
    take(8'h04, "R6 status layout", 2);
    take(8'h04, "R8 status repeat", 0);
    deselect();

    // R7: busy masks the status
    busy = 1'b1; prot = 2'b11; wel = 1'b1;
    select(); send(8'h05);
    take(8'h01, "R7 busy mask", 0);
    take(8'h01, "R7 busy mask", 0);
    deselect();
    busy = 1'b0;

    // R9: unknown opcode silences the rest of the transaction
    select(); send(8'h9F); send(8'h03); send(8'h10);
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R9 no output", {7'b0, tx_valid}, 8'h00);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    chk(tx_valid == 1'b0, "R9 still silent", {7'b0, tx_valid}, 8'h00);
    deselect();

    // R10: abort then restart
    select(); send(8'h03); send(8'h20);
    take(model[8'h20], "R2 first byte", 0);
    deselect();
    select(); send(8'h03); send(8'h33);
    take(model[8'h33], "R10 fresh decode", 0);
    deselect();

    // R4, R3: full array plus a few bytes in one read
    select(); send(8'h03); send(8'h10);
    for (int k = 0; k < 260; k++) take(model[8'(8'h10 + k)], "R4 full sweep", 0);
    deselect();

    chk(exp_q.size() == 0, "R3 all bytes seen", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule